// File: doc/BRIEF.md
# UDP/IP Transmit Packet Assembler

This block turns a stream of payload words from an input FIFO into complete Ethernet/IPv4/UDP packets. It builds them in a circular transmit buffer of 16-bit words. When it starts a packet, it takes the current write pointer as the packet base. It streams the payload to the buffer starting 21 words past that base, which leaves room for the 14-byte Ethernet header, the 20-byte IPv4 header and the 8-byte UDP header. It also folds every payload word into a ones'-complement checksum as the word passes through.

When the end-of-frame word has been taken, the block spends one cycle finishing both checksums. It then back-fills the 21 header words from the highest offset down to the lowest. The UDP header goes in first, then the IPv4 header, and the Ethernet header last. On the final header write it moves the write pointer past the packet, which tells the MAC side that a packet is ready.

Between packets, a CPU can ask for the buffer through a request/grant pair. A pending request always wins over FIFO traffic. Neither the CPU nor the FIFO is served unless the buffer has room for a full jumbo frame.

Top module: `tx_udp_assembler`

## Requirements
- R1: While reset is held and in the first cycle after it, `fifo_rd`, `buf_we` and `cpu_gnt` are 0, `wr_ptr` is 0 and `buf_empty` is 1.
- R2: A packet or a grant may start only when free space is at least 4507 words, where free space is 2^BUF_AW minus (`wr_ptr` - `rd_ptr`) taken modulo 2^(BUF_AW+1). With free space of 4506 words nothing starts. With exactly 4507 words a packet proceeds.
- R3: In the idle state, a high `cpu_req` with enough space raises `cpu_gnt` one cycle later. The grant stays high while the request is held and drops one cycle after the request drops. While it is granted, `fifo_rd` and `buf_we` stay 0. A request that arrives together with FIFO data wins. A request made during assembly is granted only after that packet is published.
- R4: Payload word i is written at buffer address base+21+i. Bits [15:8] carry the earlier byte.
- R5: When `fifo_odd` is high on the end-of-frame word, only its upper byte counts. The low byte is written as 0x00, and the payload length counts one byte for that word.
- R6: All header words are written after the last payload word, one per cycle, at offsets 20 down to 0 in strictly decreasing order (UDP, then IPv4, then Ethernet).
- R7: Offsets 0-2 hold the destination MAC, offsets 3-5 hold the source MAC (most significant word first), and offset 6 holds 0x0800.
- R8: Offsets 7-16 hold 0x4500, total length (payload bytes + 28), 0x0000, 0x0000, {TTL=64, 0x11}, the header checksum (complement of the ones'-complement sum of the other nine words), source IP and destination IP.
- R9: Offsets 17-20 hold the source port, the destination port, the UDP length (payload bytes + 8) and the checksum. The checksum is the complement of the ones'-complement sum over the pseudo-header (both IPs, 0x0011, UDP length), the UDP header and the zero-padded payload. A computed value of 0x0000 is written as 0xFFFF.
- R10: In the cycle of the offset-0 write, `wr_ptr` becomes base+21+payload words. `buf_empty` equals (`wr_ptr` == `rd_ptr`) as it was one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_data | input | 16 | Payload word from the show-ahead FIFO |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_eof | input | 1 | Current word ends the frame |
| fifo_odd | input | 1 | With `fifo_eof`: only bits [15:8] are payload |
| fifo_rd | output | 1 | Pop strobe; a word is taken when this and `fifo_valid` are both high |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | BUF_AW | Buffer word address |
| buf_wdata | output | 16 | Buffer write data |
| rd_ptr | input | BUF_AW+1 | MAC-side read pointer |
| wr_ptr | output | BUF_AW+1 | Published write pointer |
| buf_empty | output | 1 | No published packet is waiting |
| mac_dst | input | 48 | Destination MAC address |
| mac_src | input | 48 | Source MAC address |
| ip_src | input | 32 | Source IPv4 address |
| ip_dst | input | 32 | Destination IPv4 address |
| port_src | input | 16 | UDP source port |
| port_dst | input | 16 | UDP destination port |
| cpu_req | input | 1 | CPU asks for the buffer |
| cpu_gnt | output | 1 | CPU holds the buffer |

## Verification
The space limit is the hardest condition to reach from the ports. The default buffer would need several thousand words of unread packets before free space dropped below one jumbo frame. The bench avoids that by placing `rd_ptr` a chosen distance behind `wr_ptr`, one word on each side of the limit. A second hard case is a UDP checksum that comes out to zero. The bench reaches it by solving for the last payload word so that the full sum folds to 0xFFFF. It also raises a CPU request in the middle of a packet with random FIFO gaps, to show that the grant waits for publication.

// File: rtl/tx_asm_pkg.sv
package tx_asm_pkg;

  localparam int HDR_WORDS = 21;
  localparam int HDR_LAST  = HDR_WORDS - 1;
  localparam logic [15:0] ETH_TYPE_V4 = 16'h0800;
  localparam logic [15:0] IP_VER_IHL  = 16'h4500;
  localparam logic [7:0]  PROTO_UDP   = 8'h11;
  localparam int UDP_HDR_BYTES = 8;
  localparam int IP_HDR_BYTES  = 20;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CPU,
    S_PAY,
    S_CALC,
    S_HDR
  } asm_state_t;

  // 16-bit ones'-complement add with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

endpackage

// File: rtl/tx_asm_acc.sv
module tx_asm_acc
  import tx_asm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [15:0] din,
  output logic [15:0] sum
);

  always_ff @(posedge clk) begin
    if (rst || clr) sum <= 16'd0;
    else if (en)    sum <= oc_add(sum, din);
  end

endmodule

// File: rtl/tx_asm_ocsum.sv
module tx_asm_ocsum
  import tx_asm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0][15:0] terms,
  output logic [15:0]        sum
);

  always_comb begin
    sum = 16'd0;
    for (int i = 0; i < N; i++) sum = oc_add(sum, terms[i]);
  end

endmodule

// File: rtl/tx_asm_space.sv
module tx_asm_space #(
  parameter int AW   = 13,
  parameter int NEED = 4507
) (
  input  logic [AW:0] wr_ptr,
  input  logic [AW:0] rd_ptr,
  output logic        ok
);

  localparam logic [AW+1:0] CAP   = {2'b01, {AW{1'b0}}};
  localparam logic [AW+1:0] NEEDW = (AW+2)'(NEED);

  logic [AW:0]   used;
  logic [AW+1:0] free_w;

  always_comb begin
    used   = wr_ptr - rd_ptr;
    free_w = CAP - {1'b0, used};
    ok     = (free_w >= NEEDW);
  end

endmodule

// File: rtl/tx_asm_hdr.sv
module tx_asm_hdr
  import tx_asm_pkg::*;
#(
  parameter int TTL = 64
) (
  input  logic [4:0]  idx,
  input  logic [47:0] mac_dst,
  input  logic [47:0] mac_src,
  input  logic [31:0] ip_src,
  input  logic [31:0] ip_dst,
  input  logic [15:0] port_src,
  input  logic [15:0] port_dst,
  input  logic [15:0] tot_len,
  input  logic [15:0] udp_len,
  input  logic [15:0] ip_ck,
  input  logic [15:0] udp_ck,
  output logic [15:0] word
);

  localparam logic [7:0] TTL_B = 8'(TTL);

  always_comb begin
    case (idx)
      5'd0:    word = mac_dst[47:32];
      5'd1:    word = mac_dst[31:16];
      5'd2:    word = mac_dst[15:0];
      5'd3:    word = mac_src[47:32];
      5'd4:    word = mac_src[31:16];
      5'd5:    word = mac_src[15:0];
      5'd6:    word = ETH_TYPE_V4;
      5'd7:    word = IP_VER_IHL;
      5'd8:    word = tot_len;
      5'd9:    word = 16'h0000;
      5'd10:   word = 16'h0000;
      5'd11:   word = {TTL_B, PROTO_UDP};
      5'd12:   word = ip_ck;
      5'd13:   word = ip_src[31:16];
      5'd14:   word = ip_src[15:0];
      5'd15:   word = ip_dst[31:16];
      5'd16:   word = ip_dst[15:0];
      5'd17:   word = port_src;
      5'd18:   word = port_dst;
      5'd19:   word = udp_len;
      5'd20:   word = udp_ck;
      default: word = 16'h0000;
    endcase
  end

endmodule

// File: rtl/tx_udp_assembler.sv
module tx_udp_assembler
  import tx_asm_pkg::*;
#(
  parameter int BUF_AW      = 13,
  parameter int JUMBO_BYTES = 9014,
  parameter int IP_TTL      = 64,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       fifo_data,
  input  logic              fifo_valid,
  input  logic              fifo_eof,
  input  logic              fifo_odd,
  output logic              fifo_rd,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [15:0]       buf_wdata,
  input  logic [BUF_AW:0]   rd_ptr,
  output logic [BUF_AW:0]   wr_ptr,
  output logic              buf_empty,
  input  logic [47:0]       mac_dst,
  input  logic [47:0]       mac_src,
  input  logic [31:0]       ip_src,
  input  logic [31:0]       ip_dst,
  input  logic [15:0]       port_src,
  input  logic [15:0]       port_dst,
  input  logic              cpu_req,
  output logic              cpu_gnt
);

  localparam int PW          = BUF_AW + 1;
  localparam int JUMBO_WORDS = (JUMBO_BYTES + 1) / 2;
  localparam logic [PW-1:0] HDR_OFF = PW'(HDR_WORDS);
  localparam logic [7:0]    TTL_B   = 8'(IP_TTL);

  asm_state_t       state;
  logic [PW-1:0]    base;
  logic [CNT_W-1:0] nwords;
  logic [15:0]      nbytes;
  logic [4:0]       hidx;
  logic [15:0]      udp_ck, ip_ck;

  logic        space_ok;
  logic        take;
  logic [15:0] pay_word;
  logic [15:0] psum;
  logic [15:0] udp_len, tot_len;
  logic [15:0] udp_raw, ip_raw, udp_fin;
  logic [15:0] hdr_word;
  logic [PW-1:0] pay_ptr, hdr_ptr, end_ptr;

  assign fifo_rd = (state == S_PAY);
  assign take    = fifo_rd && fifo_valid;
  assign pay_word = (fifo_eof && fifo_odd) ? {fifo_data[15:8], 8'h00} : fifo_data;
  assign udp_len = nbytes + 16'(UDP_HDR_BYTES);
  assign tot_len = nbytes + 16'(UDP_HDR_BYTES + IP_HDR_BYTES);
  assign pay_ptr = base + HDR_OFF + PW'(nwords);
  assign hdr_ptr = base + PW'(hidx);
  assign end_ptr = base + HDR_OFF + PW'(nwords);

  tx_asm_space #(.AW(BUF_AW), .NEED(JUMBO_WORDS)) u_space (
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .ok     (space_ok)
  );

  tx_asm_acc u_acc (
    .clk (clk),
    .rst (rst),
    .clr (state == S_IDLE),
    .en  (take),
    .din (pay_word),
    .sum (psum)
  );

  tx_asm_ocsum #(.N(10)) u_udp_sum (
    .terms ({psum, ip_src[31:16], ip_src[15:0], ip_dst[31:16], ip_dst[15:0],
             {8'h00, PROTO_UDP}, udp_len, port_src, port_dst, udp_len}),
    .sum   (udp_raw)
  );

  tx_asm_ocsum #(.N(9)) u_ip_sum (
    .terms ({IP_VER_IHL, tot_len, 16'h0000, 16'h0000, {TTL_B, PROTO_UDP},
             ip_src[31:16], ip_src[15:0], ip_dst[31:16], ip_dst[15:0]}),
    .sum   (ip_raw)
  );

  assign udp_fin = (~udp_raw == 16'h0000) ? 16'hFFFF : ~udp_raw;

  tx_asm_hdr #(.TTL(IP_TTL)) u_hdr (
    .idx      (hidx),
    .mac_dst  (mac_dst),
    .mac_src  (mac_src),
    .ip_src   (ip_src),
    .ip_dst   (ip_dst),
    .port_src (port_src),
    .port_dst (port_dst),
    .tot_len  (tot_len),
    .udp_len  (udp_len),
    .ip_ck    (ip_ck),
    .udp_ck   (udp_ck),
    .word     (hdr_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      base      <= '0;
      wr_ptr    <= '0;
      nwords    <= '0;
      nbytes    <= '0;
      hidx      <= '0;
      udp_ck    <= '0;
      ip_ck     <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      cpu_gnt   <= 1'b0;
      buf_empty <= 1'b1;
    end else begin
      buf_we    <= 1'b0;
      buf_empty <= (wr_ptr == rd_ptr);
      case (state)
        S_IDLE: begin
          if (space_ok) begin
            if (cpu_req) begin
              cpu_gnt <= 1'b1;
              state   <= S_CPU;
            end else if (fifo_valid) begin
              base   <= wr_ptr;
              nwords <= '0;
              nbytes <= '0;
              state  <= S_PAY;
            end
          end
        end
        S_CPU: begin
          if (!cpu_req) begin
            cpu_gnt <= 1'b0;
            state   <= S_IDLE;
          end
        end
        S_PAY: begin
          if (fifo_valid) begin
            buf_we    <= 1'b1;
            buf_addr  <= pay_ptr[BUF_AW-1:0];
            buf_wdata <= pay_word;
            nwords    <= nwords + 1'b1;
            nbytes    <= nbytes + ((fifo_eof && fifo_odd) ? 16'd1 : 16'd2);
            if (fifo_eof) state <= S_CALC;
          end
        end
        S_CALC: begin
          udp_ck <= udp_fin;
          ip_ck  <= ~ip_raw;
          hidx   <= 5'(HDR_LAST);
          state  <= S_HDR;
        end
        S_HDR: begin
          buf_we    <= 1'b1;
          buf_addr  <= hdr_ptr[BUF_AW-1:0];
          buf_wdata <= hdr_word;
          if (hidx == 5'd0) begin
            wr_ptr <= end_ptr;
            state  <= S_IDLE;
          end else begin
            hidx <= hidx - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tx_udp_assembler_chk.sv
module tx_udp_assembler_chk #(
  parameter int BUF_AW = 13
) (
  input logic            clk,
  input logic            rst,
  input logic            fifo_rd,
  input logic            buf_we,
  input logic            cpu_req,
  input logic            cpu_gnt,
  input logic [BUF_AW:0] wr_ptr
);

  // R3: the buffer belongs to the CPU exclusively while granted
  a_r3_gnt_blocks_fifo: assert property (@(posedge clk) disable iff (rst)
    cpu_gnt |-> (!fifo_rd && !buf_we));

  // R3: a grant only follows a request
  a_r3_gnt_from_req: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_gnt) |-> $past(cpu_req));

  // R3: a held request keeps the grant
  a_r3_gnt_hold: assert property (@(posedge clk) disable iff (rst)
    (cpu_gnt && cpu_req) |=> cpu_gnt);

  // R3: FIFO traffic never starts over a pending request
  a_r3_req_priority: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_rd) |-> !$past(cpu_req));

  // R10: the pointer moves only together with the final header write
  a_r10_ptr_with_write: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr != $past(wr_ptr)) |-> buf_we);

endmodule

bind tx_udp_assembler tx_udp_assembler_chk #(.BUF_AW(BUF_AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .fifo_rd (fifo_rd),
  .buf_we  (buf_we),
  .cpu_req (cpu_req),
  .cpu_gnt (cpu_gnt),
  .wr_ptr  (wr_ptr)
);

// File: tb/tx_udp_assembler_test.sv
module tx_udp_assembler_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int PMASK = (1 << (AW + 1)) - 1;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] fifo_data = '0;
  logic fifo_valid = 1'b0, fifo_eof = 1'b0, fifo_odd = 1'b0;
  logic fifo_rd, buf_we, buf_empty, cpu_gnt;
  logic [AW-1:0] buf_addr;
  logic [15:0] buf_wdata;
  logic [AW:0] rd_ptr = '0;
  logic [AW:0] wr_ptr;
  logic [47:0] mdst = '0, msrc = '0;
  logic [31:0] isrc = '0, idst = '0;
  logic [15:0] psrc = '0, pdst = '0;
  logic cpu_req = 1'b0;

  int vectors = 0, fails = 0;
  logic [15:0] pl [0:99];
  int nw, nb;
  logic [15:0] cap [0:127];
  int base_a;
  bit hdr_started;
  int last_hdr, order_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_udp_assembler uut (
    .clk(clk), .rst(rst), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
    .fifo_eof(fifo_eof), .fifo_odd(fifo_odd), .fifo_rd(fifo_rd),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .buf_empty(buf_empty),
    .mac_dst(mdst), .mac_src(msrc), .ip_src(isrc), .ip_dst(idst),
    .port_src(psrc), .port_dst(pdst), .cpu_req(cpu_req), .cpu_gnt(cpu_gnt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // buffer write monitor, sampled away from the clock edge
  always @(negedge clk) begin
    if (!rst && buf_we) begin
      int off;
      off = (int'(buf_addr) - base_a) & AMASK;
      if (off < 128) cap[off] = buf_wdata;
      if (off < 21) begin
        if (hdr_started && off >= last_hdr) order_bad++;
        hdr_started = 1'b1;
        last_hdr = off;
      end else if (hdr_started) begin
        order_bad++;
      end
    end
  end

  function automatic logic [15:0] fold(input logic [31:0] s);
    logic [31:0] t;
    t = s;
    while (t[31:16] != 16'd0) t = {16'd0, t[15:0]} + {16'd0, t[31:16]};
    return t[15:0];
  endfunction

  function automatic logic [15:0] pay_exp(input int i);
    if (i == nw - 1 && (nb % 2) == 1) return {pl[i][15:8], 8'h00};
    return pl[i];
  endfunction

  function automatic logic [15:0] udp_exp();
    logic [31:0] s;
    logic [15:0] ul, c;
    ul = 16'(nb + 8);
    s = 32'(isrc[31:16]) + 32'(isrc[15:0]) + 32'(idst[31:16]) + 32'(idst[15:0])
      + 32'h11 + 32'(ul) + 32'(psrc) + 32'(pdst) + 32'(ul);
    for (int i = 0; i < nw; i++) s = s + 32'(pay_exp(i));
    c = ~fold(s);
    return (c == 16'h0000) ? 16'hFFFF : c;
  endfunction

  function automatic logic [15:0] ip_exp();
    logic [31:0] s;
    s = 32'h4500 + 32'(nb + 28) + 32'h4011 + 32'(isrc[31:16]) + 32'(isrc[15:0])
      + 32'(idst[31:16]) + 32'(idst[15:0]);
    return ~fold(s);
  endfunction

  function automatic logic [15:0] hdr_exp(input int k);
    case (k)
      0: return mdst[47:32];  1: return mdst[31:16];  2: return mdst[15:0];
      3: return msrc[47:32];  4: return msrc[31:16];  5: return msrc[15:0];
      6: return 16'h0800;     7: return 16'h4500;     8: return 16'(nb + 28);
      9: return 16'h0000;     10: return 16'h0000;    11: return 16'h4011;
      12: return ip_exp();
      13: return isrc[31:16]; 14: return isrc[15:0];
      15: return idst[31:16]; 16: return idst[15:0];
      17: return psrc;        18: return pdst;        19: return 16'(nb + 8);
      default: return udp_exp();
    endcase
  endfunction

  task automatic rand_cfg();
    mdst = {$urandom, $urandom}; msrc = {$urandom, $urandom};
    isrc = $urandom; idst = $urandom;
    psrc = 16'($urandom); pdst = 16'($urandom);
  endtask

  task automatic fill(input int bytes);
    nb = bytes;
    nw = (bytes + 1) / 2;
    for (int i = 0; i < nw; i++) pl[i] = 16'($urandom);
  endtask

  // drives the payload, waits for publication, then checks the buffer image
  task automatic run_packet(input int gap);
    int base_full, exp_wr, early_gnt, t, i;
    bit took;
    base_full = int'(wr_ptr);
    base_a = base_full & AMASK;
    hdr_started = 1'b0;
    last_hdr = 99;
    order_bad = 0;
    early_gnt = 0;
    for (int k = 0; k < 128; k++) cap[k] = 16'hDEAD;
    exp_wr = (base_full + 21 + nw) & PMASK;
    i = 0;
    while (i < nw) begin
      @(negedge clk);
      if (cpu_gnt) early_gnt++;
      if ($urandom_range(99) < gap) begin
        fifo_valid = 1'b0;
      end else begin
        fifo_valid = 1'b1;
        fifo_eof = (i == nw - 1);
        fifo_odd = (i == nw - 1) && (nb % 2 == 1);
        fifo_data = fifo_odd ? {pl[i][15:8], 8'($urandom)} : pl[i];
      end
      #1 took = fifo_valid && fifo_rd;
      @(posedge clk);
      if (took) i++;
    end
    @(negedge clk);
    fifo_valid = 1'b0; fifo_eof = 1'b0; fifo_odd = 1'b0;
    t = 0;
    while (int'(wr_ptr) != exp_wr && t < 100) begin
      if (cpu_gnt) early_gnt++;
      @(negedge clk);
      t++;
    end
    check("R10 wr_ptr after publish", 32'(wr_ptr), 32'(exp_wr));
    check("R3 no grant during assembly", 32'(early_gnt), 32'd0);
    @(negedge clk);
    check("R10 buf_empty low after publish", 32'(buf_empty), 32'd0);
    rd_ptr = wr_ptr;
    @(negedge clk);
    check("R10 buf_empty high after drain", 32'(buf_empty), 32'd1);
    for (int k = 0; k < 7; k++) check("R7 MAC header word", 32'(cap[k]), 32'(hdr_exp(k)));
    for (int k = 7; k < 17; k++) check("R8 IPv4 header word", 32'(cap[k]), 32'(hdr_exp(k)));
    for (int k = 17; k < 21; k++) check("R9 UDP header word", 32'(cap[k]), 32'(hdr_exp(k)));
    for (int k = 0; k < nw; k++) begin
      if (k == nw - 1 && nb % 2 == 1) check("R5 odd tail padded", 32'(cap[21+k]), 32'(pay_exp(k)));
      else check("R4 payload word", 32'(cap[21+k]), 32'(pay_exp(k)));
    end
    check("R6 header order after payload", 32'(order_bad), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int bad;
    void'($urandom(32'd1234));
    rand_cfg();
    repeat (3) @(negedge clk);
    check("R1 fifo_rd in reset", 32'(fifo_rd), 0);
    check("R1 cpu_gnt in reset", 32'(cpu_gnt), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 buf_we after reset", 32'(buf_we), 0);
    check("R1 wr_ptr after reset", 32'(wr_ptr), 0);
    check("R1 buf_empty after reset", 32'(buf_empty), 1);

    // directed short lengths, then random traffic
    foreach (pl[j]) pl[j] = 16'h0;
    fill(1); run_packet(0);
    fill(2); run_packet(0);
    fill(3); rand_cfg(); run_packet(40);
    for (int n = 0; n < 12; n++) begin
      rand_cfg();
      fill($urandom_range(1, 200));
      run_packet(30);
    end

    // R9 corner: checksum folding to zero is sent as 0xFFFF
    rand_cfg();
    fill(40);
    pl[nw-1] = 16'h0000;
    begin
      logic [31:0] s;
      logic [15:0] ul;
      ul = 16'(nb + 8);
      s = 32'(isrc[31:16]) + 32'(isrc[15:0]) + 32'(idst[31:16]) + 32'(idst[15:0])
        + 32'h11 + 32'(ul) + 32'(psrc) + 32'(pdst) + 32'(ul);
      for (int i = 0; i < nw; i++) s = s + 32'(pl[i]);
      pl[nw-1] = 16'hFFFF - fold(s);
    end
    run_packet(10);
    check("R9 zero checksum sent as FFFF", 32'(cap[20]), 32'hFFFF);

    // R3: request arriving together with FIFO data wins
    @(negedge clk);
    fifo_valid = 1'b1; fifo_data = 16'h1234; cpu_req = 1'b1;
    bad = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (fifo_rd || buf_we) bad++;
    end
    check("R3 grant given over FIFO", 32'(cpu_gnt), 1);
    check("R3 no FIFO pop or write while granted", 32'(bad), 0);
    fifo_valid = 1'b0;
    cpu_req = 1'b0;
    @(negedge clk);
    check("R3 grant drops after request", 32'(cpu_gnt), 0);

    // R3: request raised in the middle of assembly waits for publication
    rand_cfg();
    fill(120);
    fork
      run_packet(20);
      begin
        wait (fifo_rd === 1'b1);
        repeat (5) @(negedge clk);
        cpu_req = 1'b1;
      end
    join
    @(negedge clk);
    check("R3 deferred grant after publish", 32'(cpu_gnt), 1);
    cpu_req = 1'b0;
    repeat (2) @(negedge clk);

    // R2: one word short of a jumbo frame blocks both paths
    rd_ptr = (AW+1)'((int'(wr_ptr) - 3686) & PMASK);
    fifo_valid = 1'b1; fifo_data = 16'h5555;
    bad = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (fifo_rd) bad++;
    end
    check("R2 no start below jumbo space", 32'(bad), 0);
    cpu_req = 1'b1;
    bad = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (cpu_gnt) bad++;
    end
    check("R2 no grant below jumbo space", 32'(bad), 0);
    cpu_req = 1'b0;
    fifo_valid = 1'b0;
    @(negedge clk);
    // exactly jumbo space: packet proceeds
    rd_ptr = (AW+1)'((int'(wr_ptr) - 3685) & PMASK);
    rand_cfg();
    fill(17);
    run_packet(0);

    repeat (3) @(negedge clk);
    report();
  end

endmodule